// File: doc/BRIEF.md
# Exception Acceptance and Vectoring Unit

This unit sits next to a simple CPU pipeline and decides, cycle by cycle, whether one of the pending exception events is taken. It also decides how the interrupted instruction is treated and which return address is kept. Four treatments exist:

- **Cancel**: the instruction is dropped and re-executed after the handler.
- **Abandon**: nothing is kept.
- **Suspend**: a long string or block instruction is stopped part-way and restarted from its own address.
- **Complete**: the instruction finishes and the next address is kept.

For every accepted event the unit produces three things. It captures the return PC and the old status word. It builds the status word the handler runs with. It computes the address from which the handler vector is fetched. That address comes from a fixed table, from a relocatable table whose base is supplied by the core, or from a dedicated fast-interrupt vector register.

Most events save their context on a stack through a two-word push handshake. The fast interrupt instead marks its context for the backup PC and backup status registers. A reset event saves nothing.

The core supplies three things: an instruction-boundary flag, a flag for "a long string instruction is in progress", and the current and next PC. The stack memory, the interrupt controller and the decoder live outside the unit.

Top module: `exc_accept_unit`

## Requirements
- R1: A `cpu_reset` event is accepted in every cycle, including during a push sequence, which it aborts. It reports kind 0 and mode 1 (abandon). It saves nothing: `save_pc` = 0, `save_psw` = 0, and neither `save_to_stack` nor `save_to_bkp` is set. Its vector is `FIXED_BASE + 4*(FIXED_SLOTS-1)`, and its `new_psw` has only bit `SUP_BIT` set.
- R2: When the unit is idle, undefined-instruction (kind 1), privileged-instruction (kind 2) and floating-point (kind 3) faults are accepted whatever the boundary flags say. They report mode 0 (cancel) and save `cur_pc`. Their vectors are the fixed slots 1, 0 and 2 respectively (`FIXED_BASE + 4*slot`).
- R3: An NMI or interrupt that arrives while `long_busy` is high is accepted at once with mode 2 (suspend), and `cur_pc` is saved.
- R4: An NMI or interrupt without `long_busy` is held off until `at_boundary` is high. It is then accepted with mode 3 (complete), and `next_pc` is saved.
- R5: A trap (kind 7) is accepted only when `at_boundary` is high. It reports mode 3, saves `next_pc`, and vectors to `intb + 4*trap_num`.
- R6: NMI (kind 4) vectors to fixed slot 3. A normal interrupt (kind 6) vectors to `intb + 4*irq_vec`. A fast interrupt (kind 5) vectors to `fintv`.
- R7: A fast interrupt sets `save_to_bkp`, never requests a push, and raises `acc_done` in the same cycle as `acc_valid`. Every other non-reset kind sets `save_to_stack`.
- R8: A stack save behaves as follows:
  - `push_req` rises in the cycle `acc_valid` is high.
  - The first word pushed is the saved PSW and the second is the saved PC.
  - Each word is held until `push_ack`.
  - `acc_done` pulses in the cycle after the second acknowledge.
  - `push_ack` has no effect while `push_req` is low.
- R9: Acceptance follows a fixed priority, highest first: reset, undefined, privileged, floating-point, NMI, fast interrupt, normal interrupt, trap. At most one event is accepted per cycle. `acc_valid` pulses for one cycle in the cycle after the event is sampled.
- R10: `save_psw` is the `psw_in` value sampled at acceptance. `new_psw` equals that value with bit `IE_BIT` cleared and bit `SUP_BIT` set.
- R11: While a push sequence is running (`busy` high), only a reset event can be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the unit |
| cpu_reset | input | 1 | Reset exception event |
| nmi_req | input | 1 | Non-maskable interrupt request |
| irq_req | input | 1 | Maskable interrupt request |
| irq_fast | input | 1 | Marks the request as a fast interrupt |
| irq_vec | input | VEC_W | Interrupt vector number |
| flt_undef | input | 1 | Undefined-instruction fault |
| flt_priv | input | 1 | Privileged-instruction fault |
| flt_fpu | input | 1 | Floating-point fault |
| trap_req | input | 1 | Unconditional trap request |
| trap_num | input | VEC_W | Trap number |
| at_boundary | input | 1 | Core is between two instructions |
| long_busy | input | 1 | A long string/block instruction is executing |
| cur_pc | input | WORD_W | Address of the current instruction |
| next_pc | input | WORD_W | Address of the next instruction |
| psw_in | input | WORD_W | Current status word |
| intb | input | WORD_W | Relocatable vector table base |
| fintv | input | WORD_W | Fast interrupt handler address |
| push_ack | input | 1 | Stack accepted the pushed word |
| acc_valid | output | 1 | One-cycle acceptance strobe |
| acc_kind | output | 3 | Accepted event kind |
| acc_mode | output | 2 | Treatment of the instruction |
| acc_done | output | 1 | Context save finished |
| busy | output | 1 | Push sequence in progress |
| save_pc | output | WORD_W | Return address kept |
| save_psw | output | WORD_W | Status word kept |
| new_psw | output | WORD_W | Status word for the handler |
| vec_addr | output | WORD_W | Vector fetch address |
| save_to_stack | output | 1 | Context goes to the stack |
| save_to_bkp | output | 1 | Context goes to backup registers |
| push_req | output | 1 | Stack push request |
| push_data | output | WORD_W | Word to push |

## Verification
The bench builds the unit with a 32-bit word, 8-bit vector numbers, sixteen fixed slots and the fixed table placed at 0x1000 instead of the top of memory. This placement lets a wrong slot offset show up as a clean numeric mismatch rather than wrapping. Random table bases and vector numbers up to 255 exercise carries in the relocatable address adder. Fast interrupts are enabled, so both save destinations and the reset-aborts-push path can be reached in the same run.

// File: rtl/exc_pkg.sv
package exc_pkg;
   typedef enum logic [2:0] {
      K_RESET = 3'd0,
      K_UNDEF = 3'd1,
      K_PRIV  = 3'd2,
      K_FPU   = 3'd3,
      K_NMI   = 3'd4,
      K_FIRQ  = 3'd5,
      K_IRQ   = 3'd6,
      K_TRAP  = 3'd7
   } exc_kind_t;

   typedef enum logic [1:0] {
      M_CANCEL   = 2'd0,
      M_ABANDON  = 2'd1,
      M_SUSPEND  = 2'd2,
      M_COMPLETE = 2'd3
   } exc_mode_t;

   typedef enum logic [1:0] {
      S_IDLE     = 2'd0,
      S_PUSH_PSW = 2'd1,
      S_PUSH_PC  = 2'd2
   } save_state_t;

   localparam int SLOT_PRIV  = 0;
   localparam int SLOT_UNDEF = 1;
   localparam int SLOT_FPU   = 2;
   localparam int SLOT_NMI   = 3;
   localparam int NUM_KINDS  = 8;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
   import exc_pkg::*;
#(
   parameter bit FAST_IRQ_EN = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      idle,
   input  logic      rst_evt,
   input  logic      f_undef,
   input  logic      f_priv,
   input  logic      f_fpu,
   input  logic      nmi,
   input  logic      irq,
   input  logic      irq_fast,
   input  logic      trap,
   input  logic      at_boundary,
   input  logic      long_busy,
   output logic      win_valid,
   output exc_kind_t win_kind,
   output exc_mode_t win_mode,
   output logic      win_use_cur
);
   logic irq_is_fast;
   logic async_ok;
   logic [NUM_KINDS-1:0] cand;
   logic [NUM_KINDS-1:0] grant;

   generate
      if (FAST_IRQ_EN) begin : g_fast
         assign irq_is_fast = irq_fast;
      end else begin : g_no_fast
         assign irq_is_fast = 1'b0;
      end
   endgenerate

   assign async_ok = long_busy | at_boundary;

   always_comb begin
      cand                 = '0;
      cand[int'(K_RESET)]  = rst_evt;
      cand[int'(K_UNDEF)]  = idle & f_undef;
      cand[int'(K_PRIV)]   = idle & f_priv;
      cand[int'(K_FPU)]    = idle & f_fpu;
      cand[int'(K_NMI)]    = idle & nmi & async_ok;
      cand[int'(K_FIRQ)]   = idle & irq & irq_is_fast & async_ok;
      cand[int'(K_IRQ)]    = idle & irq & ~irq_is_fast & async_ok;
      cand[int'(K_TRAP)]   = idle & trap & at_boundary;
   end

   // lowest index carries the highest priority
   always_comb begin
      grant    = '0;
      win_kind = K_TRAP;
      for (int i = NUM_KINDS - 1; i >= 0; i--) begin
         if (cand[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
            win_kind = exc_kind_t'(3'(i));
         end
      end
      win_valid = |cand;
   end

   always_comb begin
      case (win_kind)
         K_RESET:                win_mode = M_ABANDON;
         K_UNDEF, K_PRIV, K_FPU: win_mode = M_CANCEL;
         K_NMI, K_FIRQ, K_IRQ:   win_mode = long_busy ? M_SUSPEND : M_COMPLETE;
         default:                win_mode = M_COMPLETE;
      endcase
      win_use_cur = (win_mode == M_CANCEL) || (win_mode == M_SUSPEND);
   end

   assert_single_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   assert_trap_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && win_kind == K_TRAP) |-> at_boundary);
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
   import exc_pkg::*;
#(
   parameter int                 WORD_W      = 32,
   parameter int                 VEC_W       = 8,
   parameter logic [WORD_W-1:0]  FIXED_BASE  = {{(WORD_W-6){1'b1}}, 6'b0},
   parameter int                 FIXED_SLOTS = 16
) (
   input  exc_kind_t         kind,
   input  logic [WORD_W-1:0] intb,
   input  logic [WORD_W-1:0] fintv,
   input  logic [VEC_W-1:0]  irq_vec,
   input  logic [VEC_W-1:0]  trap_num,
   output logic [WORD_W-1:0] vec_addr
);
   localparam int RESET_SLOT = FIXED_SLOTS - 1;

   generate
      if (FIXED_SLOTS < 5) begin : g_bad_slots
         $error("exc_vector_gen: FIXED_SLOTS must leave room for five entries");
      end
      if (VEC_W + 2 > WORD_W) begin : g_bad_vec
         $error("exc_vector_gen: scaled vector number exceeds the word width");
      end
      if (FIXED_BASE[1:0] != 2'b00) begin : g_bad_base
         $error("exc_vector_gen: fixed table base must be word aligned");
      end
   endgenerate

   function automatic logic [WORD_W-1:0] fixed_entry(input int slot);
      return FIXED_BASE + WORD_W'(slot * 4);
   endfunction

   function automatic logic [WORD_W-1:0] reloc_entry(input logic [VEC_W-1:0] num);
      return intb + (WORD_W'(num) << 2);
   endfunction

   always_comb begin
      case (kind)
         K_RESET: vec_addr = fixed_entry(RESET_SLOT);
         K_UNDEF: vec_addr = fixed_entry(SLOT_UNDEF);
         K_PRIV:  vec_addr = fixed_entry(SLOT_PRIV);
         K_FPU:   vec_addr = fixed_entry(SLOT_FPU);
         K_NMI:   vec_addr = fixed_entry(SLOT_NMI);
         K_FIRQ:  vec_addr = fintv;
         K_IRQ:   vec_addr = reloc_entry(irq_vec);
         default: vec_addr = reloc_entry(trap_num);
      endcase
   end
endmodule

// File: rtl/exc_save_seq.sv
module exc_save_seq
   import exc_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        abort,
   input  logic        push_ack,
   output save_state_t state,
   output logic        push_req,
   output logic        sel_pc,
   output logic        done_now
);
   save_state_t state_nx;

   always_comb begin
      state_nx = state;
      if (abort) begin
         state_nx = S_IDLE;
      end else begin
         case (state)
            S_IDLE:     if (start)    state_nx = S_PUSH_PSW;
            S_PUSH_PSW: if (push_ack) state_nx = S_PUSH_PC;
            S_PUSH_PC:  if (push_ack) state_nx = S_IDLE;
            default:                  state_nx = S_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= S_IDLE;
      else        state <= state_nx;
   end

   assign push_req = (state != S_IDLE);
   assign sel_pc   = (state == S_PUSH_PC);
   assign done_now = (state == S_PUSH_PC) && push_ack && !abort;

   assert_pc_after_psw_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_PUSH_PC && $past(state) != S_PUSH_PC) |-> $past(state) == S_PUSH_PSW);
endmodule

// File: rtl/exc_accept_unit.sv
module exc_accept_unit
   import exc_pkg::*;
#(
   parameter int                 WORD_W      = 32,
   parameter int                 VEC_W       = 8,
   parameter logic [WORD_W-1:0]  FIXED_BASE  = {{(WORD_W-6){1'b1}}, 6'b0},
   parameter int                 FIXED_SLOTS = 16,
   parameter int                 IE_BIT      = 16,
   parameter int                 SUP_BIT     = 20,
   parameter bit                 FAST_IRQ_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_reset,
   input  logic              nmi_req,
   input  logic              irq_req,
   input  logic              irq_fast,
   input  logic [VEC_W-1:0]  irq_vec,
   input  logic              flt_undef,
   input  logic              flt_priv,
   input  logic              flt_fpu,
   input  logic              trap_req,
   input  logic [VEC_W-1:0]  trap_num,
   input  logic              at_boundary,
   input  logic              long_busy,
   input  logic [WORD_W-1:0] cur_pc,
   input  logic [WORD_W-1:0] next_pc,
   input  logic [WORD_W-1:0] psw_in,
   input  logic [WORD_W-1:0] intb,
   input  logic [WORD_W-1:0] fintv,
   input  logic              push_ack,
   output logic              acc_valid,
   output logic [2:0]        acc_kind,
   output logic [1:0]        acc_mode,
   output logic              acc_done,
   output logic              busy,
   output logic [WORD_W-1:0] save_pc,
   output logic [WORD_W-1:0] save_psw,
   output logic [WORD_W-1:0] new_psw,
   output logic [WORD_W-1:0] vec_addr,
   output logic              save_to_stack,
   output logic              save_to_bkp,
   output logic              push_req,
   output logic [WORD_W-1:0] push_data
);
   localparam logic [WORD_W-1:0] IE_MASK  = WORD_W'(1) << IE_BIT;
   localparam logic [WORD_W-1:0] SUP_MASK = WORD_W'(1) << SUP_BIT;

   generate
      if (IE_BIT >= WORD_W || SUP_BIT >= WORD_W) begin : g_bad_bits
         $error("exc_accept_unit: status bit position outside the word");
      end
      if (IE_BIT == SUP_BIT) begin : g_same_bits
         $error("exc_accept_unit: enable and supervisor bits must differ");
      end
   endgenerate

   save_state_t       seq_state;
   logic              idle;
   logic              win_valid;
   exc_kind_t         win_kind;
   exc_mode_t         win_mode;
   logic              win_use_cur;
   logic [WORD_W-1:0] win_vec;
   logic              win_reset;
   logic              win_stack;
   logic              seq_sel_pc;
   logic              seq_done_now;

   exc_kind_t         kind_q;
   exc_mode_t         mode_q;

   assign idle      = (seq_state == S_IDLE);
   assign win_reset = win_valid && (win_kind == K_RESET);
   assign win_stack = win_valid && (win_kind != K_RESET) && (win_kind != K_FIRQ);

   exc_arbiter #(
      .FAST_IRQ_EN (FAST_IRQ_EN)
   ) i_arb (
      .clk         (clk),
      .rst_n       (rst_n),
      .idle        (idle),
      .rst_evt     (cpu_reset),
      .f_undef     (flt_undef),
      .f_priv      (flt_priv),
      .f_fpu       (flt_fpu),
      .nmi         (nmi_req),
      .irq         (irq_req),
      .irq_fast    (irq_fast),
      .trap        (trap_req),
      .at_boundary (at_boundary),
      .long_busy   (long_busy),
      .win_valid   (win_valid),
      .win_kind    (win_kind),
      .win_mode    (win_mode),
      .win_use_cur (win_use_cur)
   );

   exc_vector_gen #(
      .WORD_W      (WORD_W),
      .VEC_W       (VEC_W),
      .FIXED_BASE  (FIXED_BASE),
      .FIXED_SLOTS (FIXED_SLOTS)
   ) i_vec (
      .kind     (win_kind),
      .intb     (intb),
      .fintv    (fintv),
      .irq_vec  (irq_vec),
      .trap_num (trap_num),
      .vec_addr (win_vec)
   );

   exc_save_seq i_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (win_stack),
      .abort    (win_reset),
      .push_ack (push_ack),
      .state    (seq_state),
      .push_req (push_req),
      .sel_pc   (seq_sel_pc),
      .done_now (seq_done_now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_valid     <= 1'b0;
         acc_done      <= 1'b0;
         kind_q        <= K_RESET;
         mode_q        <= M_ABANDON;
         save_pc       <= '0;
         save_psw      <= '0;
         new_psw       <= '0;
         vec_addr      <= '0;
         save_to_stack <= 1'b0;
         save_to_bkp   <= 1'b0;
      end else begin
         acc_valid <= win_valid;
         acc_done  <= (win_valid && !win_stack) || seq_done_now;
         if (win_valid) begin
            kind_q        <= win_kind;
            mode_q        <= win_mode;
            vec_addr      <= win_vec;
            save_to_stack <= win_stack;
            save_to_bkp   <= (win_kind == K_FIRQ);
            if (win_reset) begin
               save_pc  <= '0;
               save_psw <= '0;
               new_psw  <= SUP_MASK;
            end else begin
               save_pc  <= win_use_cur ? cur_pc : next_pc;
               save_psw <= psw_in;
               new_psw  <= (psw_in & ~IE_MASK) | SUP_MASK;
            end
         end
      end
   end

   assign acc_kind  = kind_q;
   assign acc_mode  = mode_q;
   assign busy      = !idle;
   assign push_data = seq_sel_pc ? save_pc : save_psw;

   assert_reset_nosave_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_kind == K_RESET) |-> (!save_to_stack && !save_to_bkp && !push_req));

   assert_fast_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && save_to_bkp) |-> (acc_done && !push_req));

   assert_push_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && !push_ack && !cpu_reset) |=> (push_req && $stable(push_data)));

   assert_psw_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_kind != K_RESET) |-> (!new_psw[IE_BIT] && new_psw[SUP_BIT]));

   assert_busy_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !cpu_reset) |=> !acc_valid);
endmodule

// File: tb/test_exc_accept_unit.sv
module test_exc_accept_unit;
   localparam int          WORD_W = 32;
   localparam int          VEC_W  = 8;
   localparam logic [31:0] FB     = 32'h0000_1000;
   localparam int          SLOTS  = 16;
   localparam int          IEB    = 16;
   localparam int          SUPB   = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_reset = 0, nmi_req = 0, irq_req = 0, irq_fast = 0;
   logic flt_undef = 0, flt_priv = 0, flt_fpu = 0, trap_req = 0;
   logic at_boundary = 0, long_busy = 0, push_ack = 0;
   logic [VEC_W-1:0]  irq_vec = '0, trap_num = '0;
   logic [WORD_W-1:0] cur_pc = '0, next_pc = '0, psw_in = '0, intb = '0, fintv = '0;

   logic              acc_valid, acc_done, busy, save_to_stack, save_to_bkp, push_req;
   logic [2:0]        acc_kind;
   logic [1:0]        acc_mode;
   logic [WORD_W-1:0] save_pc, save_psw, new_psw, vec_addr, push_data;

   always #2 clk = ~clk;

   exc_accept_unit #(
      .WORD_W (WORD_W), .VEC_W (VEC_W), .FIXED_BASE (FB), .FIXED_SLOTS (SLOTS),
      .IE_BIT (IEB), .SUP_BIT (SUPB), .FAST_IRQ_EN (1'b1)
   ) i_exc_accept_unit (
      .clk (clk), .rst_n (rst_n), .cpu_reset (cpu_reset), .nmi_req (nmi_req),
      .irq_req (irq_req), .irq_fast (irq_fast), .irq_vec (irq_vec),
      .flt_undef (flt_undef), .flt_priv (flt_priv), .flt_fpu (flt_fpu),
      .trap_req (trap_req), .trap_num (trap_num), .at_boundary (at_boundary),
      .long_busy (long_busy), .cur_pc (cur_pc), .next_pc (next_pc),
      .psw_in (psw_in), .intb (intb), .fintv (fintv), .push_ack (push_ack),
      .acc_valid (acc_valid), .acc_kind (acc_kind), .acc_mode (acc_mode),
      .acc_done (acc_done), .busy (busy), .save_pc (save_pc), .save_psw (save_psw),
      .new_psw (new_psw), .vec_addr (vec_addr), .save_to_stack (save_to_stack),
      .save_to_bkp (save_to_bkp), .push_req (push_req), .push_data (push_data)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // reference model state: 0 idle, 1 pushing PSW, 2 pushing PC
   int          m_state = 0;
   logic        e_valid = 0, e_done = 0, e_stk = 0, e_bkp = 0;
   logic [2:0]  e_kind = 0;
   logic [1:0]  e_mode = 0;
   logic [31:0] e_pc = 0, e_psw = 0, e_npsw = 0, e_vec = 0;
   string       e_req = "R9";

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare();
      chk(acc_valid === e_valid, "R9 acc_valid", 32'(acc_valid), 32'(e_valid));
      chk(acc_done === e_done, "R8 acc_done", 32'(acc_done), 32'(e_done));
      chk(busy === (m_state != 0), "R11 busy", 32'(busy), 32'(m_state != 0));
      chk(push_req === (m_state != 0), "R8 push_req", 32'(push_req), 32'(m_state != 0));
      if (m_state != 0)
         chk(push_data === (m_state == 1 ? e_psw : e_pc), "R8 push_data order",
             push_data, (m_state == 1 ? e_psw : e_pc));
      if (e_valid) begin
         chk(acc_kind === e_kind, "R9 kind", 32'(acc_kind), 32'(e_kind));
         chk(acc_mode === e_mode, e_req, 32'(acc_mode), 32'(e_mode));
         chk(save_pc === e_pc, e_req, save_pc, e_pc);
         chk(vec_addr === e_vec, "R6 vector", vec_addr, e_vec);
         chk({save_to_stack, save_to_bkp} === {e_stk, e_bkp}, "R7 destination",
             32'({save_to_stack, save_to_bkp}), 32'({e_stk, e_bkp}));
         chk(save_psw === e_psw, "R10 save_psw", save_psw, e_psw);
         chk(new_psw === e_npsw, "R10 new_psw", new_psw, e_npsw);
      end
   endtask

   // compute the model's response to the inputs present now, advance one clock, compare
   task automatic step();
      int k = -1;
      int n_state;
      logic n_done = 0;
      bit async_ok = long_busy || at_boundary;
      logic [1:0]  t_mode = 0;
      logic [31:0] t_pc = 0, t_psw = 0, t_npsw = 0, t_vec = 0;
      string t_req = "R9";
      if (cpu_reset) k = 0;
      else if (m_state == 0) begin
         if (flt_undef) k = 1;
         else if (flt_priv) k = 2;
         else if (flt_fpu) k = 3;
         else if (nmi_req && async_ok) k = 4;
         else if (irq_req && async_ok) k = irq_fast ? 5 : 6;
         else if (trap_req && at_boundary) k = 7;
      end
      n_state = m_state;
      if (k == 0) n_state = 0;
      else if (m_state == 1 && push_ack) n_state = 2;
      else if (m_state == 2 && push_ack) begin n_state = 0; n_done = 1; end
      else if (m_state == 0 && k > 0 && k != 5) n_state = 1;
      if (k >= 0) begin
         case (k)
            0: begin t_mode = 2'd1; t_req = "R1"; end
            1, 2, 3: begin t_mode = 2'd0; t_req = "R2"; end
            4, 5, 6: begin t_mode = long_busy ? 2'd2 : 2'd3; t_req = long_busy ? "R3" : "R4"; end
            default: begin t_mode = 2'd3; t_req = "R5"; end
         endcase
         if (k == 0) begin
            t_pc = 0; t_psw = 0; t_npsw = 32'h1 << SUPB;
         end else begin
            t_pc   = (t_mode == 2'd0 || t_mode == 2'd2) ? cur_pc : next_pc;
            t_psw  = psw_in;
            t_npsw = (psw_in & ~(32'h1 << IEB)) | (32'h1 << SUPB);
         end
         case (k)
            0: t_vec = FB + 32'((SLOTS - 1) * 4);
            1: t_vec = FB + 4;
            2: t_vec = FB;
            3: t_vec = FB + 8;
            4: t_vec = FB + 12;
            5: t_vec = fintv;
            6: t_vec = intb + 32'(irq_vec) * 4;
            default: t_vec = intb + 32'(trap_num) * 4;
         endcase
         if (k == 0 || k == 5) n_done = 1;
      end
      @(posedge clk);
      @(negedge clk);
      m_state = n_state;
      e_valid = (k >= 0);
      e_done  = n_done;
      if (k >= 0) begin
         e_kind = 3'(k); e_mode = t_mode; e_pc = t_pc; e_psw = t_psw; e_npsw = t_npsw;
         e_vec = t_vec; e_stk = (k != 0 && k != 5); e_bkp = (k == 5); e_req = t_req;
      end
      compare();
   endtask

   task automatic quiet();
      cpu_reset = 0; nmi_req = 0; irq_req = 0; irq_fast = 0; flt_undef = 0;
      flt_priv = 0; flt_fpu = 0; trap_req = 0; at_boundary = 0; long_busy = 0; push_ack = 0;
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // reset state (R8, R9, R11)
      chk(acc_valid === 1'b0, "R9 reset acc_valid", 32'(acc_valid), 0);
      chk(push_req === 1'b0, "R8 reset push_req", 32'(push_req), 0);
      chk(busy === 1'b0, "R11 reset busy", 32'(busy), 0);
      rst_n = 1'b1;
      cur_pc = 32'h0000_4000; next_pc = 32'h0000_4004; psw_in = 32'h0001_00F3;
      intb = 32'h0002_0000; fintv = 32'h0003_3330; irq_vec = 8'hFF; trap_num = 8'h05;
      step();

      // R4: interrupt held off with no boundary and no long instruction
      quiet(); irq_req = 1; step(); step();
      // R3: long instruction in progress -> suspended, cur_pc saved
      long_busy = 1; step();
      quiet(); push_ack = 1; step(); step(); quiet(); step();
      // R7: fast interrupt at a boundary
      irq_req = 1; irq_fast = 1; at_boundary = 1; step();
      // R9: all events together, undefined wins over the rest
      quiet(); flt_undef = 1; flt_priv = 1; flt_fpu = 1; nmi_req = 1; irq_req = 1;
      trap_req = 1; at_boundary = 1; step();
      // R11: requests during the push are ignored; push_ack withheld
      quiet(); nmi_req = 1; at_boundary = 1; step(); step();
      // R1: reset aborts the push sequence
      quiet(); cpu_reset = 1; step();
      quiet(); push_ack = 1; step();        // R8: ack while idle has no effect
      quiet(); trap_req = 1; step();        // R5: trap waits for a boundary
      at_boundary = 1; step();
      quiet(); push_ack = 1; step(); step(); quiet(); step();

      for (int c = 0; c < 6000; c++) begin
         cpu_reset   = ($urandom_range(99) < 2);
         flt_undef   = ($urandom_range(99) < 4);
         flt_priv    = ($urandom_range(99) < 4);
         flt_fpu     = ($urandom_range(99) < 4);
         nmi_req     = ($urandom_range(99) < 6);
         irq_req     = ($urandom_range(99) < 15);
         irq_fast    = ($urandom_range(99) < 40);
         trap_req    = ($urandom_range(99) < 8);
         at_boundary = ($urandom_range(99) < 40);
         long_busy   = ($urandom_range(99) < 20);
         push_ack    = ($urandom_range(99) < 50);
         irq_vec     = 8'($urandom);
         trap_num    = 8'($urandom);
         cur_pc      = $urandom;
         next_pc     = $urandom;
         psw_in      = $urandom;
         intb        = $urandom & 32'hFFFF_FFFC;
         fintv       = $urandom & 32'hFFFF_FFFC;
         step();
      end

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule